// File: doc/BRIEF.md
# Landing Gear Sequencing Controller

This block sequences the retraction and extension of aircraft landing gear. It reads a pilot lever and three position sensors: weight on wheels, gear fully stowed and gear fully deployed. From them it drives a hydraulic pump enable, a valve direction select, a red lamp for gear in motion and a green lamp for gear down. The core is a six-state Moore machine. Its outputs are registered alongside the state, so every output changes on the same clock edge as the state it reflects.

A countdown timer inside the block enforces a minimum airborne interval before the gear may retract. The timer is held at its full load value while the aircraft waits on the ground. It counts down on every cycle after liftoff and stops at zero. Its length is given in clock cycles by `DWELL_CYCLES`. The default is derived from a clock frequency and a delay in seconds, two seconds at 50 MHz. A bench may set a short value instead.

The lever and sensors are assumed to be clean synchronous levels. Debouncing and any model of the hydraulics are outside this block.

Top module: `gear_seq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in the ground-wait state, with pump_en_o=0, valve_lower_o=0, lamp_red_o=0 and lamp_green_o=1.
- R2: Outputs are a pure function of the registered state. In the retracting state: pump=1, valve=0, red=1, green=0. In the extending state: pump=1, valve=1, red=1, green=0. In the stowed state: all four outputs are 0. In the ground-wait, dwell and deployed states: pump=0, valve=0, red=0, green=1.
- R3: From ground-wait, the machine enters the dwell state on the first edge that samples on_ground_i=0.
- R4: The timer loads DWELL_CYCLES while the state is ground-wait and counts down to zero otherwise. When on_ground_i=0 and lever_down_i=0 (lever up) are held from ground-wait, the pump turns on after exactly DWELL_CYCLES+2 clock edges, counted from the first edge that samples on_ground_i=0.
- R5: The dwell state moves to retracting only when the timer has reached zero and lever_down_i=0. With lever_down_i=1 the machine stays in dwell however long it waits.
- R6: In retracting, gear_up_i=1 moves the machine to stowed. If lever_down_i=1 on the same edge, it moves to extending instead, and this takes priority over gear_up_i.
- R7: Stowed moves to extending when lever_down_i=1 or on_ground_i=1.
- R8: Extending moves to deployed only when gear_down_i=1. The lever and on_ground_i have no effect while extending.
- R9: on_ground_i=1 in the dwell, retracting or deployed state returns the machine to ground-wait, with priority over every other transition from those states.
- R10: Deployed moves to dwell when lever_down_i=0 and on_ground_i=0. If the timer has already expired, retraction starts on the following edge.
- R11: The gear is never retracted on the ground. A cycle with pump=1 and valve=0 is always preceded by a cycle with on_ground_i=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lever_down_i | input | 1 | Pilot lever: 1 commands gear down, 0 commands gear up |
| on_ground_i | input | 1 | Weight-on-wheels sensor, 1 when on the ground |
| gear_up_i | input | 1 | 1 when the gear is fully stowed |
| gear_down_i | input | 1 | 1 when the gear is fully deployed |
| pump_en_o | output | 1 | Hydraulic pump enable |
| valve_lower_o | output | 1 | Valve direction: 1 lowering, 0 raising |
| lamp_red_o | output | 1 | Gear-in-motion lamp |
| lamp_green_o | output | 1 | Gear-down lamp |

## Verification
Two functions can meet on one edge in the retracting state. The gear-up sensor can arrive in the same cycle as the pilot moving the lever back to down. A directed sequence raises both inputs together. The expected result is extension, seen as pump=1 with valve=1, and not the stowed state. Ground contact arriving together with a lever or sensor change is the second such meeting point. Weighted random stimulus provokes both cases many more times, and every cycle is judged against a state model computed in the bench.

// File: rtl/gear_seq_pkg.sv
package gear_seq_pkg;

  typedef enum logic [2:0] {
    ST_GROUND_WAIT = 3'd0,
    ST_DWELL       = 3'd1,
    ST_RETRACT     = 3'd2,
    ST_STOWED      = 3'd3,
    ST_EXTEND      = 3'd4,
    ST_DEPLOYED    = 3'd5
  } gear_state_e;

endpackage

// File: rtl/gear_dwell_timer.sv
module gear_dwell_timer #(
  parameter int DWELL_CYCLES = 100,
  localparam int CNT_W = $clog2(DWELL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q;

  // Loaded while held, otherwise counts down and stops at zero.
  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= CNT_W'(DWELL_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/gear_seq_next.sv
module gear_seq_next
  import gear_seq_pkg::*;
(
  input  gear_state_e cur_i,
  input  logic        lever_down_i,
  input  logic        on_ground_i,
  input  logic        gear_up_i,
  input  logic        gear_down_i,
  input  logic        expired_i,
  output gear_state_e nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      ST_GROUND_WAIT: if (!on_ground_i) nxt_o = ST_DWELL;
      ST_DWELL: begin
        if (on_ground_i)                     nxt_o = ST_GROUND_WAIT;
        else if (expired_i && !lever_down_i) nxt_o = ST_RETRACT;
      end
      ST_RETRACT: begin
        if (on_ground_i)       nxt_o = ST_GROUND_WAIT;
        else if (lever_down_i) nxt_o = ST_EXTEND;
        else if (gear_up_i)    nxt_o = ST_STOWED;
      end
      ST_STOWED: if (on_ground_i || lever_down_i) nxt_o = ST_EXTEND;
      ST_EXTEND: if (gear_down_i) nxt_o = ST_DEPLOYED;
      ST_DEPLOYED: begin
        if (on_ground_i)        nxt_o = ST_GROUND_WAIT;
        else if (!lever_down_i) nxt_o = ST_DWELL;
      end
      default: nxt_o = ST_GROUND_WAIT;
    endcase
  end

endmodule

// File: rtl/gear_seq_outreg.sv
module gear_seq_outreg
  import gear_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  gear_state_e nxt_i,
  output logic        pump_en_o,
  output logic        valve_lower_o,
  output logic        lamp_red_o,
  output logic        lamp_green_o
);

  logic moving, lowering, down_lit;

  always_comb begin
    moving   = (nxt_i == ST_RETRACT) || (nxt_i == ST_EXTEND);
    lowering = (nxt_i == ST_EXTEND);
    down_lit = (nxt_i == ST_GROUND_WAIT) || (nxt_i == ST_DWELL) ||
               (nxt_i == ST_DEPLOYED);
  end

  // Decoded from the next state so outputs change on the same edge as the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en_o     <= 1'b0;
      valve_lower_o <= 1'b0;
      lamp_red_o    <= 1'b0;
      lamp_green_o  <= 1'b1;
    end else begin
      pump_en_o     <= moving;
      valve_lower_o <= lowering;
      lamp_red_o    <= moving;
      lamp_green_o  <= down_lit;
    end
  end

endmodule

// File: rtl/gear_seq_ctrl.sv
module gear_seq_ctrl
  import gear_seq_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int DWELL_SEC    = 2,
  parameter int DWELL_CYCLES = CLK_HZ * DWELL_SEC
) (
  input  logic clk,
  input  logic rst,
  input  logic lever_down_i,
  input  logic on_ground_i,
  input  logic gear_up_i,
  input  logic gear_down_i,
  output logic pump_en_o,
  output logic valve_lower_o,
  output logic lamp_red_o,
  output logic lamp_green_o
);

  gear_state_e state_q, state_d;
  logic        dwell_done;

  gear_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hold_i   (state_q == ST_GROUND_WAIT),
    .expired_o(dwell_done)
  );

  gear_seq_next u_next (
    .cur_i       (state_q),
    .lever_down_i(lever_down_i),
    .on_ground_i (on_ground_i),
    .gear_up_i   (gear_up_i),
    .gear_down_i (gear_down_i),
    .expired_i   (dwell_done),
    .nxt_o       (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_GROUND_WAIT;
    else     state_q <= state_d;
  end

  gear_seq_outreg u_out (
    .clk          (clk),
    .rst          (rst),
    .nxt_i        (rst ? ST_GROUND_WAIT : state_d),
    .pump_en_o    (pump_en_o),
    .valve_lower_o(valve_lower_o),
    .lamp_red_o   (lamp_red_o),
    .lamp_green_o (lamp_green_o)
  );

endmodule

// File: rtl/gear_seq_ctrl_chk.sv
module gear_seq_ctrl_chk
  import gear_seq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        lever_down_i,
  input logic        on_ground_i,
  input logic        gear_up_i,
  input logic        gear_down_i,
  input logic        pump_en_o,
  input logic        valve_lower_o,
  input gear_state_e state_q,
  input logic        dwell_done
);

  // R11
  no_retract_on_ground_chk: assert property (@(posedge clk) disable iff (rst)
    (pump_en_o && !valve_lower_o) |-> !$past(on_ground_i));

  // R4
  retract_after_dwell_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_en_o && !valve_lower_o) |-> $past(dwell_done));

  // R3
  liftoff_to_dwell_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GROUND_WAIT && !on_ground_i) |=> (state_q == ST_DWELL));

  // R6
  lever_beats_stow_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RETRACT && !on_ground_i && lever_down_i && gear_up_i)
      |=> (state_q == ST_EXTEND));

  // R7
  stowed_extend_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOWED && (lever_down_i || on_ground_i)) |=> (state_q == ST_EXTEND));

  // R8
  extend_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXTEND) |=> (state_q == (gear_down_i ? ST_DEPLOYED : ST_EXTEND))
      or (state_q == $past(gear_down_i ? ST_DEPLOYED : ST_EXTEND)));

  // R9
  ground_return_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_DWELL || state_q == ST_RETRACT || state_q == ST_DEPLOYED) && on_ground_i)
      |=> (state_q == ST_GROUND_WAIT));

endmodule

bind gear_seq_ctrl gear_seq_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .lever_down_i (lever_down_i),
  .on_ground_i  (on_ground_i),
  .gear_up_i    (gear_up_i),
  .gear_down_i  (gear_down_i),
  .pump_en_o    (pump_en_o),
  .valve_lower_o(valve_lower_o),
  .state_q      (state_q),
  .dwell_done   (dwell_done)
);

// File: tb/gear_seq_ctrl_bench.sv
`timescale 1ns/1ps
module gear_seq_ctrl_bench;

  localparam int DWELL = 12;
  localparam int M_GW = 0, M_DW = 1, M_RT = 2, M_ST = 3, M_EX = 4, M_DP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lever_down = 1'b1, on_ground = 1'b1, gear_up = 1'b0, gear_down = 1'b1;
  logic pump, valve, red, green;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int m_st = M_GW, m_cnt = DWELL;

  gear_seq_ctrl #(.DWELL_CYCLES(DWELL)) u_gear_seq_ctrl (
    .clk(clk), .rst(rst), .lever_down_i(lever_down), .on_ground_i(on_ground),
    .gear_up_i(gear_up), .gear_down_i(gear_down), .pump_en_o(pump),
    .valve_lower_o(valve), .lamp_red_o(red), .lamp_green_o(green)
  );

  always #10 clk = ~clk;

  // Transitions per R3, R5, R6, R7, R8, R9, R10
  function automatic int model_next(int st, bit lv, bit gnd, bit gu, bit gd, bit ex);
    case (st)
      M_GW: return gnd ? M_GW : M_DW;
      M_DW: return gnd ? M_GW : ((ex && !lv) ? M_RT : M_DW);
      M_RT: return gnd ? M_GW : (lv ? M_EX : (gu ? M_ST : M_RT));
      M_ST: return (gnd || lv) ? M_EX : M_ST;
      M_EX: return gd ? M_DP : M_EX;
      default: return gnd ? M_GW : (!lv ? M_DW : M_DP);
    endcase
  endfunction

  // Output encoding {pump, valve, red, green} per R2
  function automatic logic [3:0] model_out(int st);
    case (st)
      M_RT: return 4'b1010;
      M_EX: return 4'b1110;
      M_ST: return 4'b0000;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic check_val(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    n_tests++;
    if ({pump, valve, red, green} !== model_out(m_st)) begin
      n_fail++;
      $display("FAIL %s: pump/valve/red/green actual %b expected %b",
               tag, {pump, valve, red, green}, model_out(m_st));
    end
  endtask

  task automatic step(bit lv, bit gnd, bit gu, bit gd, string tag);
    int nxt;
    @(negedge clk);
    check_model(tag);
    lever_down = lv; on_ground = gnd; gear_up = gu; gear_down = gd;
    nxt = model_next(m_st, lv, gnd, gu, gd, m_cnt == 0);
    if (m_st == M_GW) m_cnt = DWELL;
    else if (m_cnt != 0) m_cnt--;
    @(posedge clk);
    m_st = nxt;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lever_down = 1'b1; on_ground = 1'b1; gear_up = 1'b0; gear_down = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_st = M_GW; m_cnt = DWELL;
  endtask

  // Reach retracting with lever up after liftoff and full dwell.
  task automatic go_retract();
    do_reset();
    step(0, 1, 0, 1, "R1");
    repeat (DWELL + 3) step(0, 0, 0, 1, "R4");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int edges;
    bit lv, gnd;
    void'($urandom(32'h5EED));
    do_reset();
    // R1 reset state
    check_val("R1 pump", pump, 0);
    check_val("R1 valve", valve, 0);
    check_val("R1 red", red, 0);
    check_val("R1 green", green, 1);

    // R11: lever up on the ground never retracts
    repeat (DWELL + 4) step(0, 1, 0, 1, "R11");
    check_val("R11 pump on ground", pump, 0);

    // R3/R4: exact liftoff-to-retract count
    edges = 0;
    while (pump !== 1'b1 && edges < 4 * DWELL) begin
      step(0, 0, 0, 1, "R3");
      edges++;
    end
    check_val("R4 edges to retract", edges, DWELL + 2);
    check_val("R4 valve raising", valve, 0);

    // R5: lever down holds dwell indefinitely
    do_reset();
    repeat (DWELL + 6) step(1, 0, 0, 1, "R5");
    check_val("R5 no retract with lever down", pump, 0);
    step(0, 0, 0, 1, "R5");
    check_val("R5 retract once lever up", pump, 1);

    // R6: lever down and gear-up sensor on the same edge -> extend
    step(1, 0, 1, 0, "R6");
    check_val("R6 lever priority valve", valve, 1);
    check_val("R6 lever priority pump", pump, 1);

    // R8: lever and ground ignored while extending
    step(0, 1, 0, 0, "R8");
    check_val("R8 still extending", valve, 1);
    step(0, 0, 0, 1, "R8");
    check_val("R8 deployed green", green, 1);
    check_val("R8 deployed pump", pump, 0);

    // R10: deployed, lever up airborne -> dwell, then retract (timer expired)
    step(0, 0, 0, 0, "R10");
    check_val("R10 dwell pump", pump, 0);
    step(0, 0, 0, 0, "R10");
    check_val("R10 retract pump", pump, 1);
    check_val("R10 retract valve", valve, 0);

    // R6: stow on sensor
    step(0, 0, 1, 0, "R6");
    check_val("R6 stowed lamps", {pump, red, green}, 0);

    // R7: ground contact while stowed -> extend
    step(0, 1, 0, 0, "R7");
    check_val("R7 extend on ground", valve, 1);

    // R7: lever down while stowed -> extend
    go_retract();
    step(0, 0, 1, 0, "R7");
    step(1, 0, 0, 0, "R7");
    check_val("R7 extend on lever", {pump, valve}, 3);

    // R9: ground contact mid-retraction -> ground-wait
    go_retract();
    step(0, 1, 1, 0, "R9");
    check_val("R9 pump off", pump, 0);
    check_val("R9 green", green, 1);
    repeat (3) step(0, 1, 0, 0, "R11");
    check_val("R11 stays grounded", pump, 0);

    // Random phase, model-checked every cycle (R2)
    do_reset();
    lv = 1'b1; gnd = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0)  lv = ~lv;
      if ($urandom % 12 == 0) gnd = ~gnd;
      step(lv, gnd, ($urandom % 4) == 0, ($urandom % 4) == 0, "R2");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule